// File: doc/BRIEF.md
# Priority-Driven Pin Function Selector

This block decides, for each of a small group of package pins, which signal the pin carries. A bank of 32-bit control words sits behind a simple word-addressed bus. A strap word is sampled while reset is held and is read-only afterwards. Every pin owns up to five ranked signal slots, with slot 0 ranked highest. Each slot is enabled by an OR of product terms. Each product term is an AND of field comparisons. A comparison takes a one- or two-bit field from any control word or from the strap word and tests it against a constant.

The pin takes the highest-ranked slot whose condition holds. When no slot holds, the pin takes its fallback signal. The select outputs are derived combinationally from the stored words. The pads, the GPIO data paths and the electrical settings sit outside this block. They consume the per-pin select code.

Top module: `pmx_top`

## Requirements
- R1: Control words live at byte offsets 0x80, 0x84, 0x88, 0x8C, 0x90, 0x94 (words C0..C5), 0xA0, 0xA4, 0xA8, 0xAC (words C6..C9) and 0x3C (reset-control word K). Each is written whole on a clock edge with `bus_we` high. Each reads back combinationally on `bus_rdata` when addressed. All of them are zero after reset.
- R2: A read at any other offset returns zero. A write to any other offset changes no stored word and no select.
- R3: While `rst_n` is low the strap word S follows `strap_i` on every clock. Once reset is released S is held and reads back at offset 0x70. Writes to 0x70 are ignored.
- R4: `pin_sel[3p+2:3p]` is the code of pin p. Code k (0..4) means slot k is active, and code 5 means fallback. Slot k is active only if its condition is true and no lower-numbered slot of that pin is true.
- R5: The simple pins. Pin 0 has slot 0 = C0[0]. Pin 1 has slot 0 = C4[22] and slot 1 = C0[4]. Pin 2 has slot 0 = C0[12] OR S[14]. Pin 3 has slot 0 = C0[25] and slot 1 = C7[12] OR S[19]==0.
- R6: Pin 4 has both slots gated by K[3] AND C0[15]. With that gate true, C4[31]==0 gives code 0 and C4[31]==1 gives code 1. Otherwise the code is 5.
- R7: Video-mode field M = C4[5:4], where 0 means off and 1, 2, 3 mean the 18-, 24- and 30-bit modes. Pin 5 has slot 0 = C1[17] AND M!=0 and slot 1 = C1[17]. Pin 6 has slot 0 = C1[22] AND M==3 and slot 1 = C1[22].
- R8: Pin 7 uses only slots 0, 2 and 4, and its fallback is a peripheral signal. Slot 0 (its GPIO role) = C6[0], slot 2 = S[6]==0, and slot 4 = C9[3].
- R9: When S[14] is 1, pin 2 reports code 0 whatever software writes to C0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; strap sampling window |
| strap_i | input | 32 | Strap word source |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 8 | Byte offset of the addressed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pin_sel | output | 3*NUM_PINS | Per-pin active slot code |

## Verification
The cases that are hardest to reach from the ports are those where the strap word outranks software. Examples are pin 2 held on slot 0, and pin 3 or pin 7 sitting on a lower slot with every control word cleared. These states only change across a reset. The stimulus therefore restarts the block several times with different strap words, each followed by a run of random writes. Other cases need several words to agree at once: the three-bit gate of pin 4 and the exact video modes of pins 5 and 6. These are reached by directed write sequences that sweep the mode field and the gate bits, on top of random data at mapped and unmapped offsets.

// File: rtl/pmx_pkg.sv
package pmx_pkg;
   localparam int REG_W      = 32;
   localparam int ADDR_W     = 8;
   localparam int NSLOT      = 5;
   localparam int NALT       = 3;
   localparam int NTERM      = 3;
   localparam int NSRC       = 12;
   localparam int SRC_W      = $clog2(NSRC);
   localparam int SEL_W      = $clog2(NSLOT + 1);
   localparam int TABLE_PINS = 8;
   localparam int SRC_K      = 10;
   localparam int SRC_S      = 11;

   typedef struct packed {
      logic             used;
      logic [SRC_W-1:0] src;
      logic [4:0]       lsb;
      logic             wide;
      logic [1:0]       val;
   } term_t;

   typedef term_t [NTERM-1:0] prod_t;
   typedef logic [NSRC-1:0][REG_W-1:0] regview_t;

   function automatic term_t tm(int src, int lsb, bit wide, int val);
      term_t t;
      t.used = 1'b1;
      t.src  = SRC_W'(src);
      t.lsb  = 5'(lsb);
      t.wide = wide;
      t.val  = 2'(val);
      return t;
   endfunction

   // product term number alt of slot of pin; unused terms stay zero
   function automatic prod_t product_of(int pin, int slot, int alt);
      prod_t p;
      p = '0;
      case (pin)
         0: if (slot == 0 && alt == 0) p[0] = tm(0, 0, 0, 1);
         1: if (alt == 0) begin
               if (slot == 0) p[0] = tm(4, 22, 0, 1);
               if (slot == 1) p[0] = tm(0, 4, 0, 1);
            end
         2: if (slot == 0) begin
               if (alt == 0) p[0] = tm(0, 12, 0, 1);
               if (alt == 1) p[0] = tm(SRC_S, 14, 0, 1);
            end
         3: begin
               if (slot == 0 && alt == 0) p[0] = tm(0, 25, 0, 1);
               if (slot == 1 && alt == 0) p[0] = tm(7, 12, 0, 1);
               if (slot == 1 && alt == 1) p[0] = tm(SRC_S, 19, 0, 0);
            end
         4: if (alt == 0 && slot < 2) begin
               p[0] = tm(SRC_K, 3, 0, 1);
               p[1] = tm(0, 15, 0, 1);
               p[2] = tm(4, 31, 0, slot);
            end
         5: begin
               if (slot == 0) begin
                  p[0] = tm(4, 4, 1, alt + 1);
                  p[1] = tm(1, 17, 0, 1);
               end
               if (slot == 1 && alt == 0) p[0] = tm(1, 17, 0, 1);
            end
         6: if (alt == 0) begin
               if (slot == 0) begin
                  p[0] = tm(4, 4, 1, 3);
                  p[1] = tm(1, 22, 0, 1);
               end
               if (slot == 1) p[0] = tm(1, 22, 0, 1);
            end
         7: if (alt == 0) begin
               if (slot == 0) p[0] = tm(6, 0, 0, 1);
               if (slot == 2) p[0] = tm(SRC_S, 6, 0, 0);
               if (slot == 4) p[0] = tm(9, 3, 0, 1);
            end
         default: ;
      endcase
      return p;
   endfunction

   function automatic logic term_hit(regview_t rv, term_t t);
      logic [REG_W-1:0] w;
      logic [1:0] fld;
      w   = rv[t.src] >> t.lsb;
      fld = t.wide ? w[1:0] : {1'b0, w[0]};
      return !t.used || (fld == t.val);
   endfunction

   function automatic logic prod_hit(regview_t rv, prod_t p);
      logic h;
      h = p[0].used;
      for (int i = 0; i < NTERM; i++) h &= term_hit(rv, p[i]);
      return h;
   endfunction

   // decode: {valid, index}
   function automatic logic [SRC_W:0] decode_addr(logic [ADDR_W-1:0] a);
      logic [SRC_W:0] r;
      r = '0;
      if (a[1:0] == 2'b00) begin
         if (a >= 8'h80 && a <= 8'h94) r = {1'b1, SRC_W'((a - 8'h80) >> 2)};
         else if (a >= 8'hA0 && a <= 8'hAC) r = {1'b1, SRC_W'(((a - 8'hA0) >> 2) + 6)};
         else if (a == 8'h3C) r = {1'b1, SRC_W'(SRC_K)};
         else if (a == 8'h70) r = {1'b1, SRC_W'(SRC_S)};
      end
      return r;
   endfunction
endpackage

// File: rtl/pmx_regbank.sv
module pmx_regbank
   import pmx_pkg::*;
#(
   parameter int N_WR = NSRC - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [REG_W-1:0]  strap_i,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [REG_W-1:0]  wdata,
   output logic [REG_W-1:0]  rdata,
   output regview_t          regs
);
   if (N_WR != NSRC - 1) begin : g_bad_nwr
      $error("pmx_regbank: strap must be the only read-only source");
   end

   logic [SRC_W:0] dec;
   assign dec = decode_addr(addr);

   for (genvar g = 0; g < N_WR; g++) begin : g_word
      always_ff @(posedge clk) begin
         if (!rst_n)                                 regs[g] <= '0;
         else if (we && dec[SRC_W] && dec[SRC_W-1:0] == SRC_W'(g)) regs[g] <= wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) regs[SRC_S] <= strap_i;
   end

   assign rdata = dec[SRC_W] ? regs[dec[SRC_W-1:0]] : '0;
endmodule

// File: rtl/pmx_slot_eval.sv
module pmx_slot_eval
   import pmx_pkg::*;
#(
   parameter int PIN = 0
) (
   input  regview_t         regs,
   output logic [NSLOT-1:0] slot_hit
);
   if (PIN < 0 || PIN >= TABLE_PINS) begin : g_bad_pin
      $error("pmx_slot_eval: pin index outside table");
   end

   logic [NALT-1:0] alt_hit [NSLOT];

   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      for (genvar e = 0; e < NALT; e++) begin : g_alt
         localparam prod_t PROD = product_of(PIN, s, e);
         assign alt_hit[s][e] = prod_hit(regs, PROD);
      end
      assign slot_hit[s] = |alt_hit[s];
   end
endmodule

// File: rtl/pmx_prio_pick.sv
module pmx_prio_pick #(
   parameter int NREQ = 5,
   parameter int SW   = 3
) (
   input  logic [NREQ-1:0] req,
   output logic [SW-1:0]   sel
);
   if ((1 << SW) <= NREQ) begin : g_bad_sw
      $error("pmx_prio_pick: select too narrow for fallback code");
   end

   always_comb begin
      sel = SW'(NREQ);
      for (int i = NREQ - 1; i >= 0; i--) begin
         if (req[i]) sel = SW'(i);
      end
   end
endmodule

// File: rtl/pmx_top.sv
module pmx_top
   import pmx_pkg::*;
#(
   parameter int NUM_PINS = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [31:0]               strap_i,
   input  logic                      bus_we,
   input  logic [7:0]                bus_addr,
   input  logic [31:0]               bus_wdata,
   output logic [31:0]               bus_rdata,
   output logic [3*NUM_PINS-1:0]     pin_sel
);
   if (NUM_PINS < 1 || NUM_PINS > TABLE_PINS) begin : g_bad_pins
      $error("pmx_top: NUM_PINS outside expression table");
   end
   if (SEL_W != 3 || REG_W != 32 || ADDR_W != 8) begin : g_bad_w
      $error("pmx_top: port widths disagree with package");
   end

   regview_t reg_view;

   pmx_regbank u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .strap_i (strap_i),
      .we      (bus_we),
      .addr    (bus_addr),
      .wdata   (bus_wdata),
      .rdata   (bus_rdata),
      .regs    (reg_view)
   );

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      logic [NSLOT-1:0] hit;
      pmx_slot_eval #(.PIN(p)) u_eval (
         .regs     (reg_view),
         .slot_hit (hit)
      );
      pmx_prio_pick #(.NREQ(NSLOT), .SW(SEL_W)) u_pick (
         .req (hit),
         .sel (pin_sel[SEL_W*p +: SEL_W])
      );
   end
endmodule

// File: rtl/pmx_chk.sv
module pmx_chk
   import pmx_pkg::*;
#(
   parameter int NUM_PINS = 8
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  bus_we,
   input logic [7:0]            bus_addr,
   input logic [31:0]           bus_wdata,
   input logic [31:0]           bus_rdata,
   input logic [3*NUM_PINS-1:0] pin_sel,
   input regview_t              reg_view
);
   logic mapped;
   assign mapped = (bus_addr == 8'h3C) || (bus_addr == 8'h70) ||
                   (bus_addr inside {8'h80, 8'h84, 8'h88, 8'h8C, 8'h90, 8'h94,
                                     8'hA0, 8'hA4, 8'hA8, 8'hAC});

   p_write_lands_r1: assert property (@(posedge clk) disable iff (!rst_n)
      bus_we && bus_addr == 8'h80 |=> reg_view[0] == $past(bus_wdata));

   p_unmapped_inert_r2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_we && !mapped |=> $stable(reg_view));

   p_unmapped_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !mapped |-> bus_rdata == '0);

   p_strap_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> $stable(reg_view[SRC_S]));

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_rng
      p_code_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
         pin_sel[3*p +: 3] <= 3'd5);
   end

   if (NUM_PINS > 4) begin : g_p4
      p_gate_split_r6: assert property (@(posedge clk) disable iff (!rst_n)
         !reg_view[4][31] |-> pin_sel[14:12] != 3'd1);
   end

   if (NUM_PINS > 2) begin : g_p2
      p_strap_force_r9: assert property (@(posedge clk) disable iff (!rst_n)
         reg_view[SRC_S][14] |-> pin_sel[8:6] == 3'd0);
   end
endmodule

bind pmx_top pmx_chk #(.NUM_PINS(NUM_PINS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .pin_sel   (pin_sel),
   .reg_view  (reg_view)
);

// File: tb/pmx_top_bench.sv
module pmx_top_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] strap_i = '0;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [23:0] pin_sel;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #2 clk = ~clk;

   pmx_top u_pmx_top (.*);

   logic [31:0] m_c [10];
   logic [31:0] m_k, m_s;

   function automatic int widx(logic [7:0] a);
      case (a)
         8'h80: return 0;  8'h84: return 1;  8'h88: return 2;  8'h8C: return 3;
         8'h90: return 4;  8'h94: return 5;  8'hA0: return 6;  8'hA4: return 7;
         8'hA8: return 8;  8'hAC: return 9;  8'h3C: return 10; 8'h70: return 11;
         default: return -1;
      endcase
   endfunction

   function automatic logic [31:0] m_read(logic [7:0] a);
      int i = widx(a);
      if (i < 0) return 0;
      if (i == 10) return m_k;
      if (i == 11) return m_s;
      return m_c[i];
   endfunction

   function automatic int m_sel(int p);
      logic [1:0] mode = m_c[4][5:4];
      case (p)
         0: return m_c[0][0] ? 0 : 5;
         1: return m_c[4][22] ? 0 : (m_c[0][4] ? 1 : 5);
         2: return (m_c[0][12] || m_s[14]) ? 0 : 5;
         3: return m_c[0][25] ? 0 : ((m_c[7][12] || !m_s[19]) ? 1 : 5);
         4: return (m_k[3] && m_c[0][15]) ? (m_c[4][31] ? 1 : 0) : 5;
         5: return m_c[1][17] ? ((mode != 0) ? 0 : 1) : 5;
         6: return m_c[1][22] ? ((mode == 3) ? 0 : 1) : 5;
         default: return m_c[6][0] ? 0 : (!m_s[6] ? 2 : (m_c[9][3] ? 4 : 5));
      endcase
   endfunction

   function automatic string ptag(int p);
      if (p < 4) return "R5";
      if (p == 4) return "R6";
      if (p < 7) return "R7";
      return "R8";
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic chk_pins(string extra);
      for (int p = 0; p < 8; p++)
         chk({ptag(p), "/R4 ", extra, $sformatf(" pin%0d", p)}, 32'(pin_sel[3*p +: 3]), 32'(m_sel(p)));
   endtask

   // drive at negedge, check read of pre-write state, apply at posedge
   task automatic step(bit we, logic [7:0] a, logic [31:0] d);
      int i;
      @(negedge clk);
      bus_we = we; bus_addr = a; bus_wdata = d;
      #1;
      chk((widx(a) < 0) ? "R2 read" : "R1/R3 read", bus_rdata, m_read(a));
      @(posedge clk);
      i = widx(a);
      if (we && i >= 0 && i < 10) m_c[i] = d;
      if (we && i == 10) m_k = d;
      #1;
      bus_we = 1'b0;
      chk_pins("step");
   endtask

   task automatic do_reset(logic [31:0] sv);
      @(negedge clk);
      rst_n = 1'b0; strap_i = 32'hFFFF_FFFF;
      repeat (2) @(posedge clk);
      @(negedge clk);
      strap_i = sv;
      @(posedge clk);
      for (int i = 0; i < 10; i++) m_c[i] = '0;
      m_k = '0; m_s = sv;
      @(negedge clk);
      rst_n = 1'b1; strap_i = ~sv;
      #1;
      chk_pins("reset R1");
   endtask

   task automatic rand_run(int n);
      logic [7:0] a;
      for (int j = 0; j < n; j++) begin
         case ($urandom_range(0, 5))
            0: a = 8'(4 * $urandom_range(0, 63));
            1: a = 8'h3C;
            2: a = 8'h70;
            default: a = 8'h80 + 8'(4 * $urandom_range(0, 11));
         endcase
         step($urandom_range(0, 3) != 0, a, $urandom());
      end
   endtask

   initial begin
      #800000;
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      do_reset(32'h0);
      for (int i = 0; i < 12; i++) step(1'b0, widx(8'h80) >= 0 ? 8'h80 + 8'(4 * i) : 8'h0, '0);
      chk("R3 strap read", 32'(0), m_s);
      step(1'b0, 8'h70, '0);
      step(1'b1, 8'h70, 32'hDEAD_BEEF);           // R3 ignored write
      step(1'b0, 8'h70, '0);
      step(1'b1, 8'h84 + 8'h2, 32'hFFFF_FFFF);    // R2 unaligned
      step(1'b1, 8'h40, 32'hFFFF_FFFF);           // R2 unmapped
      step(1'b0, 8'h84, '0);
      // R4 priority on pin 1: both slots true
      step(1'b1, 8'h80, 32'h0000_0010);
      step(1'b1, 8'h90, 32'h0040_0000);
      chk("R4 pin1 high wins", 32'(pin_sel[5:3]), 32'd0);
      // R6 gate sweep
      step(1'b1, 8'h3C, 32'h8);
      step(1'b1, 8'h80, 32'h0000_8000);
      chk("R6 gate c31=0", 32'(pin_sel[14:12]), 32'd0);
      step(1'b1, 8'h90, 32'h8000_0000);
      chk("R6 gate c31=1", 32'(pin_sel[14:12]), 32'd1);
      step(1'b1, 8'h3C, 32'h0);
      chk("R6 gate off", 32'(pin_sel[14:12]), 32'd5);
      // R7 mode sweep with both enables
      step(1'b1, 8'h84, 32'h0042_0000);
      for (int md = 0; md < 4; md++) begin
         step(1'b1, 8'h90, 32'(md) << 4);
         chk("R7 pin5 mode", 32'(pin_sel[17:15]), (md != 0) ? 32'd0 : 32'd1);
         chk("R7 pin6 mode", 32'(pin_sel[20:18]), (md == 3) ? 32'd0 : 32'd1);
      end
      // R8 pin 7 skipped slots
      step(1'b1, 8'hAC, 32'h8);
      chk("R8 strap slot2", 32'(pin_sel[23:21]), 32'd2);
      step(1'b1, 8'hA0, 32'h1);
      chk("R8 gpio slot0", 32'(pin_sel[23:21]), 32'd0);
      rand_run(400);

      do_reset(32'h0008_4040);
      chk("R9 strap force", 32'(pin_sel[8:6]), 32'd0);
      chk("R8 slot4 after strap", 32'(pin_sel[23:21]), 32'd5);
      step(1'b0, 8'h70, '0);
      step(1'b1, 8'h80, 32'h0);
      chk("R9 write C0 zero", 32'(pin_sel[8:6]), 32'd0);
      step(1'b1, 8'hAC, 32'h8);
      chk("R8 slot4", 32'(pin_sel[23:21]), 32'd4);
      rand_run(400);

      do_reset(32'hA5A5_5A5A);
      rand_run(400);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule